// File: doc/BRIEF.md
# Stepped Clock Phase Offset Controller

This block holds the signed phase offset that a fine delay line applies to a clock, and decides how that offset may move. A build-time mode selects one of three behaviours: the offset is held at zero, the offset is held at a configured constant, or the offset is moved at run time one unit at a time. In the run-time mode, a requester pulses a step enable together with a direction bit. The controller then waits a configurable settling time, which stands in for the delay line taking up the new tap. After that wait it applies the unit step and raises a one-cycle done pulse.

The offset is bounded to plus or minus a configured limit (255 by default). A step that would cross the bound is refused: the offset holds, a status bit reports the refusal, and the step still completes with done, so the requester never hangs. Requests that arrive while a step is still settling are dropped. All inputs are sampled, and all outputs change, on the rising edge of the phase-step clock.

Top module: `phase_step_ctrl`

## Requirements
- R1: When rst_n is low (asynchronous, active low), offset goes to FIXED_OFFSET when MODE is 1 and to 0 otherwise. step_done and overflow go to 0.
- R2: offset always stays between -LIMIT and +LIMIT inclusive.
- R3: With MODE 2, an accepted request with step_up=1 raises offset by exactly 1. With step_up=0 it lowers offset by exactly 1.
- R4: step_done is high for exactly one cycle. It rises SETTLE_CYCLES rising edges after the edge that accepted the request, and the new offset appears in that same cycle.
- R5: A step_en seen from the accepting edge up to and including the edge at which step_done rises is ignored. A step_en seen while step_done is high is accepted as a new request.
- R6: A step that would move offset past +LIMIT or -LIMIT leaves offset unchanged, sets overflow to 1 and still produces step_done.
- R7: overflow is updated whenever a step completes: it becomes 0 when that step was applied.
- R8: With MODE 0, offset stays 0 and step_done never rises, whatever step_en does.
- R9: With MODE 1, offset stays at FIXED_OFFSET, step_done never rises and overflow stays 0, whatever step_en does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-step control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Request one offset step (MODE 2 only) |
| step_up | input | 1 | Step direction: 1 increments, 0 decrements |
| offset | output | OFS_W | Current signed phase offset |
| step_done | output | 1 | One-cycle pulse when a step has completed |
| overflow | output | 1 | Last completed step was refused at the bound |

## Verification
The embedded properties assume that the inputs are clean, synchronous levels sampled at the rising edge. They also assume that FIXED_OFFSET lies within the limit, so the range property holds from reset onward. The bench meets these assumptions by changing step_en and step_up only on falling edges and by choosing a fixed offset of -37. One shared stimulus drives run-time, fixed and zero-mode instances together. Each accepted request is held for one edge, except in the scenarios that deliberately repeat a request while a step is pending or during its done cycle.

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int MODE          = 2,
  parameter int FIXED_OFFSET  = 0,
  parameter int SETTLE_CYCLES = 4,
  parameter int LIMIT         = 255,
  parameter int OFS_W         = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic                    step_up,
  output logic signed [OFS_W-1:0] offset,
  output logic                    step_done,
  output logic                    overflow
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic signed [OFS_W-1:0] TOP  = OFS_W'(LIMIT);
  localparam logic signed [OFS_W-1:0] BOT  = OFS_W'(-LIMIT);
  localparam logic signed [OFS_W-1:0] ONE  = OFS_W'(1);
  localparam logic signed [OFS_W-1:0] INIT = (MODE == 1) ? OFS_W'(FIXED_OFFSET) : '0;
  localparam logic [CNT_W-1:0] WAIT0 = CNT_W'(SETTLE_CYCLES - 1);

  logic signed [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] cnt_q;
  logic busy_q, dir_q, done_q, ovf_q;

  wire accept  = (MODE == 2) && step_en && !busy_q;
  wire finish  = busy_q && (cnt_q == '0);
  wire blocked = dir_q ? (ofs_q == TOP) : (ofs_q == BOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= INIT;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= WAIT0;
        dir_q  <= step_up;
      end else if (finish) begin
        busy_q <= 1'b0;
        ovf_q  <= blocked;
        if (!blocked) ofs_q <= dir_q ? ofs_q + ONE : ofs_q - ONE;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign offset    = ofs_q;
  assign step_done = done_q;
  assign overflow  = ovf_q;

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    offset >= BOT && offset <= TOP);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);

  a_r4_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset) |-> step_done);

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !overflow) |->
      (offset == $past(offset) + ONE || offset == $past(offset) - ONE));

  a_r6_hold_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && overflow) |-> $stable(offset));

endmodule

// File: tb/phase_step_ctrl_test.sv
`timescale 1ns/1ps
module phase_step_ctrl_test;
  localparam int N   = 4;
  localparam int FIX = -37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0;
  logic step_up = 1'b0;
  logic signed [8:0] ofs_v, ofs_f, ofs_z;
  logic d_v, d_f, d_z, o_v, o_f, o_z;
  int tests = 0, fails = 0, idle_done = 0;
  int model = 0;

  always #2.5 clk = ~clk;

  phase_step_ctrl #(.MODE(2), .SETTLE_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up),
    .offset(ofs_v), .step_done(d_v), .overflow(o_v));
  phase_step_ctrl #(.MODE(1), .FIXED_OFFSET(FIX), .SETTLE_CYCLES(N)) u_fix (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up),
    .offset(ofs_f), .step_done(d_f), .overflow(o_f));
  phase_step_ctrl #(.MODE(0), .SETTLE_CYCLES(N)) u_zero (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up),
    .offset(ofs_z), .step_done(d_z), .overflow(o_z));

  always @(negedge clk) if (rst_n && (d_f || d_z)) idle_done++;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    step_en = 1'b0;
    repeat (2) @(negedge clk);
    check(ofs_v == 0, "R1 var offset", ofs_v, 0);
    check(ofs_f == FIX, "R1 fixed offset", ofs_f, FIX);
    check(ofs_z == 0, "R1 zero offset", ofs_z, 0);
    check(!d_v && !o_v, "R1 done/overflow low", {d_v, o_v}, 0);
    rst_n = 1'b1;
    model = 0;
  endtask

  task automatic one_step(input logic up, input logic exp_ovf, input string req);
    int hits = 0, at = -1;
    @(negedge clk) begin step_en = 1'b1; step_up = up; end
    @(negedge clk) step_en = 1'b0;
    for (int k = 0; k <= N + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (d_v) begin hits++; at = k; end
    end
    if (!exp_ovf) model = up ? model + 1 : model - 1;
    check(hits == 1 && at == N, {req, " R4 done timing"}, at, N);
    check(ofs_v == model, {req, " offset"}, ofs_v, model);
    check(o_v == exp_ovf, {req, " overflow"}, o_v, exp_ovf);
  endtask

  task automatic test_pending_ignored();
    int hits = 0;
    @(negedge clk) begin step_en = 1'b1; step_up = 1'b1; end
    @(negedge clk) step_en = 1'b0;
    for (int k = 0; k <= 2 * N + 3; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 2 || k == N - 1) step_en = 1'b1;
      if (k == 3 || k == N) step_en = 1'b0;
      if (d_v) hits++;
    end
    model++;
    check(hits == 1, "R5 repeat while pending ignored", hits, 1);
    check(ofs_v == model, "R5 offset moved once", ofs_v, model);
  endtask

  task automatic test_accept_in_done();
    int hits = 0, last = -1;
    @(negedge clk) begin step_en = 1'b1; step_up = 1'b0; end
    @(negedge clk) step_en = 1'b0;
    for (int k = 0; k <= 2 * N + 3; k++) begin
      if (k > 0) @(negedge clk);
      if (k == N) begin
        check(d_v == 1'b1, "R4 done in first window", d_v, 1);
        step_en = 1'b1;
      end
      if (k == N + 1) step_en = 1'b0;
      if (d_v) begin hits++; last = k; end
    end
    model -= 2;
    check(hits == 2 && last == 2 * N + 1, "R5 request in done cycle accepted", last, 2 * N + 1);
    check(ofs_v == model, "R3 two decrements", ofs_v, model);
  endtask

  task automatic test_upper_bound();
    while (model < 255) one_step(1'b1, 1'b0, "R3 climb");
    check(ofs_v == 255, "R2 reached top", ofs_v, 255);
    one_step(1'b1, 1'b1, "R6 refused above top");
    one_step(1'b0, 1'b0, "R7 overflow cleared");
  endtask

  task automatic test_lower_bound();
    while (model > -255) one_step(1'b0, 1'b0, "R3 descend");
    check(ofs_v == -255, "R2 reached bottom", ofs_v, -255);
    one_step(1'b0, 1'b1, "R6 refused below bottom");
    one_step(1'b1, 1'b0, "R7 overflow cleared again");
  endtask

  task automatic test_static_modes();
    check(ofs_z == 0, "R8 zero mode offset", ofs_z, 0);
    check(ofs_f == FIX, "R9 fixed mode offset", ofs_f, FIX);
    check(!o_f && !o_z, "R9 no overflow in static modes", {o_f, o_z}, 0);
    check(idle_done == 0, "R8 R9 no done in static modes", idle_done, 0);
  endtask

  task automatic test_reset_midstep();
    @(negedge clk) begin step_en = 1'b1; step_up = 1'b1; end
    @(negedge clk) step_en = 1'b0;
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(ofs_v == 0, "R1 async reset var", ofs_v, 0);
    check(ofs_f == FIX, "R1 async reset fixed", ofs_f, FIX);
    repeat (N + 2) @(negedge clk);
    check(!d_v, "R1 pending step dropped by reset", d_v, 0);
    rst_n = 1'b1;
    model = 0;
    one_step(1'b1, 1'b0, "R3 after reset");
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    one_step(1'b1, 1'b0, "R3 up");
    one_step(1'b1, 1'b0, "R3 up");
    one_step(1'b1, 1'b0, "R3 up");
    repeat (5) one_step(1'b0, 1'b0, "R3 down");
    test_pending_ignored();
    test_accept_in_done();
    test_upper_bound();
    test_lower_bound();
    test_static_modes();
    test_reset_midstep();
    test_static_modes();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule